// File: doc/BRIEF.md
# Bit Scan and Population Count Unit

This execution unit takes one 64-bit source operand and a two-bit operation code. It performs one of three operations. A forward scan finds the position of the lowest set bit. A reverse scan finds the position of the highest set bit. A population count totals the one bits. The unit returns a result word, a flag that says whether the destination register must be written, and the six arithmetic status flags.

Inputs are accepted whenever `in_valid` is high. Each input yields a single-cycle `out_valid` strobe on the following clock, with the result, write-enable and flags registered. The unit only reports whether a write is needed. Operand fetch, decode and register writeback belong to the surrounding pipeline. The flag state is held inside the unit between operations. This lets a scan of a zero source and the reserved code leave the untouched flags as they were.

Top module: `bsu_unit`

## Requirements
- R1: Operation code 2'b00 (forward scan) with a nonzero source returns, zero-extended, the index 0..63 of the least significant one bit, and asserts the write-enable.
- R2: Operation code 2'b01 (reverse scan) with a nonzero source returns the index 0..63 of the most significant one bit, and asserts the write-enable.
- R3: A scan (code 2'b00 or 2'b01) of a zero source drives write-enable low, sets ZF and drives the result to 0. OF, SF, AF, PF and CF keep their previous values.
- R4: A scan of a nonzero source clears ZF, OF, CF and AF. SF equals result bit 63, which is always 0. PF is 1 exactly when the low byte of the result holds an even number of one bits.
- R5: Operation code 2'b10 (population count) returns the number of one bits of the source, from 0 to 64.
- R6: Population count asserts the write-enable for every source, including zero.
- R7: Population count sets ZF only for a zero source and clears OF, SF, AF, PF and CF in every case.
- R8: Operation code 2'b11 is reserved: write-enable low, result 0, all six flags unchanged.
- R9: Result, write-enable and flags appear one clock after `in_valid` is sampled high, with `out_valid` high for exactly that cycle. Without `in_valid`, `out_valid` is low and result, write-enable and flags hold.
- R10: A synchronous active-high reset clears `out_valid`, the write-enable, the result and all six flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand and code are valid this cycle |
| in_op | input | 2 | Operation code: 00 forward scan, 01 reverse scan, 10 count, 11 reserved |
| in_src | input | 64 | Source operand |
| out_valid | output | 1 | One-cycle strobe marking fresh outputs |
| out_result | output | 64 | Result word |
| out_wr_en | output | 1 | Destination must be written |
| out_of | output | 1 | Overflow flag |
| out_sf | output | 1 | Sign flag |
| out_zf | output | 1 | Zero flag |
| out_af | output | 1 | Auxiliary flag |
| out_pf | output | 1 | Parity flag |
| out_cf | output | 1 | Carry flag |

## Verification
The hardest behaviour to observe is the partial flag update of a zero-source scan: only ZF moves, and the other flags must show what an earlier operation left. A value of zero in those flags would hide a design that clears them. The stimulus therefore first runs a nonzero scan that leaves PF set, then scans a zero source and expects both PF and ZF high with no write. The reserved code gets the same treatment after a count of zero has left ZF set.

// File: rtl/bsu_pkg.sv
package bsu_pkg;

    typedef enum logic [1:0] {
        OP_FWD  = 2'b00,
        OP_REV  = 2'b01,
        OP_CNT  = 2'b10,
        OP_RSVD = 2'b11
    } bsu_op_e;

    typedef struct packed {
        logic of_f;
        logic sf_f;
        logic zf_f;
        logic af_f;
        logic pf_f;
        logic cf_f;
    } bsu_flags_t;

    // Parity flag convention: 1 when the byte holds an even number of ones
    function automatic logic even_ones(input logic [7:0] b);
        return ~(^b);
    endfunction

endpackage

// File: rtl/bsu_locate.sv
module bsu_locate #(
    parameter int W        = 64,
    parameter bit FROM_TOP = 1'b0,
    localparam int IDXW    = $clog2(W)
) (
    input  logic [W-1:0]    src,
    output logic [IDXW-1:0] index
);
    generate
        if (FROM_TOP) begin : g_high
            // later (higher) hits overwrite earlier ones
            always_comb begin
                index = '0;
                for (int i = 0; i < W; i++) begin
                    if (src[i]) index = IDXW'(i);
                end
            end
        end else begin : g_low
            // walk downward so the lowest hit wins
            always_comb begin
                index = '0;
                for (int i = W - 1; i >= 0; i--) begin
                    if (src[i]) index = IDXW'(i);
                end
            end
        end
    endgenerate
endmodule

// File: rtl/bsu_ones.sv
module bsu_ones #(
    parameter int W     = 64,
    localparam int CNTW = $clog2(W + 1)
) (
    input  logic [W-1:0]    src,
    output logic [CNTW-1:0] count
);
    always_comb begin
        count = '0;
        for (int i = 0; i < W; i++) begin
            count = count + CNTW'(src[i]);
        end
    end
endmodule

// File: rtl/bsu_unit.sv
module bsu_unit #(
    parameter int W     = 64,
    localparam int IDXW = $clog2(W),
    localparam int CNTW = $clog2(W + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [1:0]   in_op,
    input  logic [W-1:0] in_src,
    output logic         out_valid,
    output logic [W-1:0] out_result,
    output logic         out_wr_en,
    output logic         out_of,
    output logic         out_sf,
    output logic         out_zf,
    output logic         out_af,
    output logic         out_pf,
    output logic         out_cf
);
    import bsu_pkg::*;

    logic [IDXW-1:0] idx_lo, idx_hi;
    logic [CNTW-1:0] ones;
    bsu_op_e         op;
    logic            src_nz;

    logic [W-1:0]    nxt_res;
    logic            nxt_wr;
    bsu_flags_t      nxt_fl, flags_q;
    logic [W-1:0]    res_q;
    logic            wr_q, vld_q;

    bsu_locate #(.W(W), .FROM_TOP(1'b0)) u_lo (.src(in_src), .index(idx_lo));
    bsu_locate #(.W(W), .FROM_TOP(1'b1)) u_hi (.src(in_src), .index(idx_hi));
    bsu_ones   #(.W(W))                  u_cnt (.src(in_src), .count(ones));

    assign op     = bsu_op_e'(in_op);
    assign src_nz = |in_src;

    always_comb begin
        nxt_res = '0;
        nxt_wr  = 1'b0;
        nxt_fl  = flags_q;
        case (op)
            OP_FWD, OP_REV: begin
                if (!src_nz) begin
                    nxt_fl.zf_f = 1'b1;
                end else begin
                    nxt_res        = W'((op == OP_REV) ? idx_hi : idx_lo);
                    nxt_wr         = 1'b1;
                    nxt_fl         = '0;
                    nxt_fl.sf_f    = nxt_res[W-1];
                    nxt_fl.pf_f    = even_ones(nxt_res[7:0]);
                end
            end
            OP_CNT: begin
                nxt_res     = W'(ones);
                nxt_wr      = 1'b1;
                nxt_fl      = '0;
                nxt_fl.zf_f = !src_nz;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q   <= 1'b0;
            res_q   <= '0;
            wr_q    <= 1'b0;
            flags_q <= '0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) begin
                res_q   <= nxt_res;
                wr_q    <= nxt_wr;
                flags_q <= nxt_fl;
            end
        end
    end

    assign out_valid  = vld_q;
    assign out_result = res_q;
    assign out_wr_en  = wr_q;
    assign out_of     = flags_q.of_f;
    assign out_sf     = flags_q.sf_f;
    assign out_zf     = flags_q.zf_f;
    assign out_af     = flags_q.af_f;
    assign out_pf     = flags_q.pf_f;
    assign out_cf     = flags_q.cf_f;

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid && $stable(out_result) && $stable({out_of, out_sf, out_zf, out_af, out_pf, out_cf})); // R9
    AST_SCAN_ZERO: assert property (@(posedge clk) disable iff (rst) in_valid && !in_op[1] && in_src == '0 |=> !out_wr_en && out_zf); // R3
    AST_FWD_HIT: assert property (@(posedge clk) disable iff (rst) in_valid && in_op == 2'b00 && in_src != '0 |=> out_wr_en && ((($past(in_src) >> out_result[IDXW-1:0]) & W'(1)) != '0)); // R1
    AST_REV_HIT: assert property (@(posedge clk) disable iff (rst) in_valid && in_op == 2'b01 && in_src != '0 |=> out_wr_en && ((($past(in_src) >> out_result[IDXW-1:0]) & W'(1)) != '0)); // R2
    AST_CNT_WRITE: assert property (@(posedge clk) disable iff (rst) in_valid && in_op == 2'b10 |=> out_wr_en && out_result <= W'(W)); // R6
    AST_CNT_FLAGS: assert property (@(posedge clk) disable iff (rst) in_valid && in_op == 2'b10 |=> !out_of && !out_sf && !out_af && !out_pf && !out_cf); // R7
    AST_RSVD_HOLD: assert property (@(posedge clk) disable iff (rst) in_valid && in_op == 2'b11 |=> !out_wr_en && $stable({out_of, out_sf, out_zf, out_af, out_pf, out_cf})); // R8

endmodule

// File: tb/bsu_unit_test.sv
module bsu_unit_test;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [1:0]  op;
        logic [63:0] src;
        logic [63:0] res;
        logic        wr;
        logic [5:0]  fl;   // {of, sf, zf, af, pf, cf}
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{2'b00, 64'h0000_0000_0000_0001, 64'd0,  1'b1, 6'b000010}, // R1 R4
        '{2'b00, 64'h8000_0000_0000_0000, 64'd63, 1'b1, 6'b000010}, // R1
        '{2'b00, 64'h0000_0000_0000_00F0, 64'd4,  1'b1, 6'b000000}, // R1 R4
        '{2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0,  1'b1, 6'b000010}, // R1
        '{2'b00, 64'h0000_0100_0000_0000, 64'd40, 1'b1, 6'b000010}, // R1
        '{2'b01, 64'h0000_0000_0000_0001, 64'd0,  1'b1, 6'b000010}, // R2
        '{2'b01, 64'hFFFF_FFFF_FFFF_FFFF, 64'd63, 1'b1, 6'b000010}, // R2
        '{2'b01, 64'h0000_0000_0001_0F00, 64'd16, 1'b1, 6'b000000}, // R2 R4
        '{2'b01, 64'h0000_0080_0000_0001, 64'd39, 1'b1, 6'b000010}, // R2
        '{2'b01, 64'h0000_0000_0000_0007, 64'd2,  1'b1, 6'b000000}, // R2 R4
        '{2'b10, 64'h0000_0000_0000_0000, 64'd0,  1'b1, 6'b001000}, // R5 R6 R7
        '{2'b10, 64'hFFFF_FFFF_FFFF_FFFF, 64'd64, 1'b1, 6'b000000}, // R5 R7
        '{2'b10, 64'h0000_0000_0000_0F0F, 64'd8,  1'b1, 6'b000000}, // R5
        '{2'b10, 64'h8000_0000_0000_0001, 64'd2,  1'b1, 6'b000000}, // R5
        '{2'b10, 64'h5555_5555_5555_5555, 64'd32, 1'b1, 6'b000000}  // R5
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  in_op = 2'b00;
    logic [63:0] in_src = '0;
    logic        out_valid, out_wr_en;
    logic [63:0] out_result;
    logic        out_of, out_sf, out_zf, out_af, out_pf, out_cf;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bsu_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_src(in_src),
        .out_valid(out_valid), .out_result(out_result), .out_wr_en(out_wr_en),
        .out_of(out_of), .out_sf(out_sf), .out_zf(out_zf), .out_af(out_af),
        .out_pf(out_pf), .out_cf(out_cf)
    );

    function automatic logic [5:0] flags_now();
        return {out_of, out_sf, out_zf, out_af, out_pf, out_cf};
    endfunction

    task automatic check(input string req, input logic exp_vld, input logic [63:0] exp_res,
                         input logic exp_wr, input logic [5:0] exp_fl);
        n_tests++;
        if (out_valid !== exp_vld || out_result !== exp_res || out_wr_en !== exp_wr
            || flags_now() !== exp_fl) begin
            n_fail++;
            $display("FAIL %s: got vld=%0b res=%0d wr=%0b fl=%06b, expected vld=%0b res=%0d wr=%0b fl=%06b",
                     req, out_valid, out_result, out_wr_en, flags_now(),
                     exp_vld, exp_res, exp_wr, exp_fl);
        end
    endtask

    // drive one operation; return at the negedge where its outputs are visible
    task automatic issue(input logic [1:0] op, input logic [63:0] src);
        @(negedge clk);
        in_valid = 1'b1;
        in_op    = op;
        in_src   = src;
        @(negedge clk);
        in_valid = 1'b0;
        in_src   = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R10 reset state", 1'b0, 64'd0, 1'b0, 6'b000000);
        rst = 1'b0;

        for (int k = 0; k < NV; k++) begin
            issue(VECS[k].op, VECS[k].src);
            check($sformatf("R1/R2/R4/R5/R6/R7 vector %0d", k), 1'b1,
                  VECS[k].res, VECS[k].wr, VECS[k].fl);
        end

        // idle cycle after the last vector: strobe drops, state holds
        @(negedge clk);
        check("R9 idle hold", 1'b0, 64'd32, 1'b1, 6'b000000);

        // R3 forward scan of zero: PF left set by the prior scan must survive
        issue(2'b00, 64'h1);
        check("R4 prime pf", 1'b1, 64'd0, 1'b1, 6'b000010);
        issue(2'b00, 64'h0);
        check("R3 fwd zero", 1'b1, 64'd0, 1'b0, 6'b001010);

        // R3 reverse scan of zero after a count left all flags clear
        issue(2'b10, 64'hFF);
        check("R5 prime clear", 1'b1, 64'd8, 1'b1, 6'b000000);
        issue(2'b01, 64'h0);
        check("R3 rev zero", 1'b1, 64'd0, 1'b0, 6'b001000);

        // R3 then nonzero scan clears ZF again (R4)
        issue(2'b01, 64'h0000_0000_0000_0100);
        check("R4 zf cleared", 1'b1, 64'd8, 1'b1, 6'b000000);

        // R8 reserved code after count of zero left ZF set
        issue(2'b10, 64'h0);
        check("R6 count zero writes", 1'b1, 64'd0, 1'b1, 6'b001000);
        issue(2'b11, 64'h0000_0000_0000_0005);
        check("R8 reserved", 1'b1, 64'd0, 1'b0, 6'b001000);
        issue(2'b00, 64'h4);
        issue(2'b11, 64'hFFFF);
        check("R8 reserved keeps scan flags", 1'b1, 64'd0, 1'b0, 6'b000000);

        // R9 back-to-back operations each give a strobe
        @(negedge clk);
        in_valid = 1'b1; in_op = 2'b10; in_src = 64'h3;
        @(negedge clk);
        check("R9 back-to-back first", 1'b1, 64'd2, 1'b1, 6'b000000);
        in_op = 2'b01; in_src = 64'h0000_0000_8000_0000;
        @(negedge clk);
        in_valid = 1'b0;
        check("R9 back-to-back second", 1'b1, 64'd31, 1'b1, 6'b000000);

        // R10 reset in mid-run clears everything
        issue(2'b10, 64'h0);
        rst = 1'b1;
        @(negedge clk);
        check("R10 mid-run reset", 1'b0, 64'd0, 1'b0, 6'b000000);
        rst = 1'b0;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule